// File: doc/BRIEF.md
# Serial Character Regenerator with Parity Check

This block takes a start-stop asynchronous serial line, already at logic levels (mark high, space low, idling at mark), and rebuilds each character on its output. It is clocked at 128 times the bit rate, so one clock cycle is one sample count and one element lasts 128 cycles. A 7-bit element timer is held at zero while the line rests at mark. A mark-to-space transition starts it. If the space does not last until the element centre, the attempt is treated as a false start: the timer goes back to idle and nothing reaches the output.

Each element is sampled at count 64 of its span. The output is a clean copy of the line, delayed by half a bit. The start element and the information elements are copied from the centre samples. The stop elements are produced by the block itself and are never taken from the line. Three static inputs set the behaviour. One selects 10-unit or 11-unit framing. One selects even or odd parity sense over the eight information elements. One enables a distortion check, which rejects transitions that lie far from an element boundary and stop elements read as space. At the end of the final stop element, a character that failed any enabled check produces a single-cycle error pulse.

Top module: `char_regen`

## Requirements
- R1: During and after reset, line_o is at mark (1) and err_o is low.
- R2: While line_i stays at mark, the element timer stays at zero, line_o stays at mark and err_o stays low. After a mark-to-space transition, the timer advances by one count per clock cycle.
- R3: A space on line_i lasting 64 cycles or fewer (the line is back at mark by count 64) is discarded. line_o does not change, err_o does not pulse, and the next character is received normally. A space lasting 65 cycles is accepted as a start element.
- R4: line_o shows the start element as space (0), then the eight information elements least significant first. Each element is the value of the line at count 64 of that element. line_o changes only in the cycle after such a centre sample, so it lags line_i by half a bit plus two cycles.
- R5: Every stop element on line_o is mark (1), even when line_i is space during that element.
- R6: A character fails parity when the XOR of its eight information elements differs from odd_par_i. With odd_par_i=0 (even sense), an odd number of ones is an error. With odd_par_i=1 (odd sense), an even number of ones is an error.
- R7: With frame11_i=0 a character is 10 elements long (start, 8 information, 1 stop). With frame11_i=1 it is 11 elements long (2 stop). Character end, the error pulse and re-arming follow the selected length.
- R8: With dist_en_i=1, a line transition inside a character at counts 33 to 95 of an element (more than 32 counts from the nearest boundary) fails the character. A transition 32 counts from the boundary does not. With dist_en_i=0, timing is never an error.
- R9: With dist_en_i=1, a stop element sampled as space fails the character. With dist_en_i=0, it does not.
- R10: A failing character produces exactly one err_o pulse, one cycle wide. The pulse comes 128×N+1 cycles after the cycle in which the start space is first presented on line_i, where N is the element count. A passing character produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 128 times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Incoming serial line, mark = 1 |
| frame11_i | input | 1 | Static: 1 selects two stop elements |
| odd_par_i | input | 1 | Static: 1 selects odd parity sense |
| dist_en_i | input | 1 | Static: enables the distortion and stop checks |
| line_o | output | 1 | Regenerated serial line, half a bit late |
| err_o | output | 1 | One-cycle pulse for a failed character |

## Verification
The hardest cases to reach are the exact edges of the timing windows. One is a start space that ends at count 64 versus count 65. The other is a transition placed at 32 versus 33 counts from its element boundary. The bench builds every character cycle by cycle from a computed list of element levels. It can move any single element boundary by a signed number of cycles, and it can replace a character with a bare space of chosen length. This lets it sit on each side of both windows and compute from the offset alone whether an error pulse is due.

// File: rtl/char_regen_pkg.sv
package char_regen_pkg;

   typedef enum logic [1:0] {
      EL_START = 2'd0,
      EL_INFO  = 2'd1,
      EL_STOP  = 2'd2
   } elem_kind_e;

   // Element 0 is the start, 1..nbits carry information, the rest are stops.
   function automatic elem_kind_e kind_of(input int unsigned idx, input int unsigned nbits);
      if (idx == 0)
         return EL_START;
      else if (idx <= nbits)
         return EL_INFO;
      else
         return EL_STOP;
   endfunction

endpackage

// File: rtl/char_regen_timer.sv
// Element timer: held at zero while idle, counts sample cycles once launched.
// The terminal count is the state in which the most significant stage is
// about to fall, i.e. the bit-clock edge that closes an element.
module char_regen_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic             halt_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             mid_o,
   output logic             term_o
);

   localparam logic [CNT_W-1:0] HALF_C = {1'b1, {(CNT_W-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_o  <= '0;
      end else if (halt_i) begin
         busy_o <= 1'b0;
         cnt_o  <= '0;
      end else if (!busy_o && launch_i) begin
         busy_o <= 1'b1;
         cnt_o  <= CNT_W'(1);
      end else if (busy_o) begin
         cnt_o  <= cnt_o + 1'b1;
      end
   end

   assign mid_o  = busy_o && (cnt_o == HALF_C);
   assign term_o = busy_o && cnt_o[CNT_W-1] && (&cnt_o[CNT_W-2:0]);

endmodule

// File: rtl/char_regen_skew.sv
// Distortion monitor: flags a line transition that falls in the middle half
// of an element, i.e. more than a quarter bit from either boundary.
module char_regen_skew #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             busy_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             late_o
);

   localparam int QTR = 2 ** (CNT_W - 2);
   localparam logic [CNT_W-1:0] LO_C = CNT_W'(QTR);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'((2 ** CNT_W) - QTR);

   logic in_window;
   assign in_window = (cnt_i > LO_C) && (cnt_i < HI_C);

   always_ff @(posedge clk) begin
      if (!rst_n)
         late_o <= 1'b0;
      else if (clear_i)
         late_o <= 1'b0;
      else if (busy_i && edge_i && in_window)
         late_o <= 1'b1;
   end

endmodule

// File: rtl/char_regen_framer.sv
// Element sequencer: confirms the start, samples centres, rebuilds the line,
// accumulates parity and stop status, and issues the end-of-character strobe.
module char_regen_framer
   import char_regen_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_s_i,
   input  logic             fall_i,
   input  logic             busy_i,
   input  logic             mid_i,
   input  logic             term_i,
   input  logic             frame11_i,
   input  logic             odd_par_i,
   input  logic             dist_en_i,
   input  logic             late_i,
   output logic             launch_o,
   output logic             halt_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             tx_o,
   output logic             err_o
);

   localparam int LAST_ONE = DATA_BITS + 1;
   localparam int LAST_TWO = DATA_BITS + 2;

   logic             confirmed;
   logic             par;
   logic             stop_bad;
   logic [IDX_W-1:0] last_idx;
   logic             abort;
   logic             done;
   logic             fail;

   assign last_idx = frame11_i ? IDX_W'(LAST_TWO) : IDX_W'(LAST_ONE);
   assign launch_o = !busy_i && fall_i;
   assign abort    = busy_i && (idx_o == '0) && !confirmed && rx_s_i;
   assign done     = busy_i && term_i && (idx_o == last_idx);
   assign halt_o   = abort || done;
   assign fail     = (par != odd_par_i) || (dist_en_i && (stop_bad || late_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o     <= '0;
         confirmed <= 1'b0;
         par       <= 1'b0;
         stop_bad  <= 1'b0;
         tx_o      <= 1'b1;
         err_o     <= 1'b0;
      end else begin
         err_o <= done && fail;
         if (launch_o) begin
            idx_o     <= '0;
            confirmed <= 1'b0;
            par       <= 1'b0;
            stop_bad  <= 1'b0;
         end else if (busy_i && !abort) begin
            if (term_i && !done)
               idx_o <= idx_o + 1'b1;
            if (mid_i) begin
               case (kind_of(int'(idx_o), DATA_BITS))
                  EL_START: begin
                     confirmed <= 1'b1;
                     tx_o      <= 1'b0;
                  end
                  EL_INFO: begin
                     tx_o <= rx_s_i;
                     par  <= par ^ rx_s_i;
                  end
                  default: begin
                     tx_o <= 1'b1;
                     if (!rx_s_i)
                        stop_bad <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/char_regen.sv
module char_regen #(
   parameter int CNT_W     = 7,
   parameter int DATA_BITS = 8,
   parameter bit HAS_SKEW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic frame11_i,
   input  logic odd_par_i,
   input  logic dist_en_i,
   output logic line_o,
   output logic err_o
);

   localparam int IDX_W = $clog2(DATA_BITS + 3);

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("char_regen: CNT_W must be at least 3");
      end
      if (DATA_BITS < 1 || DATA_BITS > 16) begin : g_bad_bits
         $error("char_regen: DATA_BITS must lie in 1..16");
      end
   endgenerate

   logic             rx_s;
   logic             rx_prev;
   logic             fall;
   logic             edge_seen;
   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             mid;
   logic             term;
   logic             launch;
   logic             halt;
   logic [IDX_W-1:0] idx;
   logic             late;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_s    <= 1'b1;
         rx_prev <= 1'b1;
      end else begin
         rx_s    <= line_i;
         rx_prev <= rx_s;
      end
   end

   assign fall      = rx_prev && !rx_s;
   assign edge_seen = rx_prev ^ rx_s;

   char_regen_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .halt_i   (halt),
      .busy_o   (busy),
      .cnt_o    (cnt),
      .mid_o    (mid),
      .term_o   (term)
   );

   generate
      if (HAS_SKEW) begin : g_skew
         char_regen_skew #(.CNT_W(CNT_W)) u_skew (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (launch),
            .busy_i  (busy),
            .edge_i  (edge_seen),
            .cnt_i   (cnt),
            .late_o  (late)
         );
      end else begin : g_no_skew
         assign late = 1'b0;
      end
   endgenerate

   char_regen_framer #(.DATA_BITS(DATA_BITS), .IDX_W(IDX_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_s_i    (rx_s),
      .fall_i    (fall),
      .busy_i    (busy),
      .mid_i     (mid),
      .term_i    (term),
      .frame11_i (frame11_i),
      .odd_par_i (odd_par_i),
      .dist_en_i (dist_en_i),
      .late_i    (late),
      .launch_o  (launch),
      .halt_o    (halt),
      .idx_o     (idx),
      .tx_o      (line_o),
      .err_o     (err_o)
   );

endmodule

// File: rtl/char_regen_chk.sv
module char_regen_chk #(
   parameter int CNT_W     = 7,
   parameter int DATA_BITS = 8,
   parameter int IDX_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic [CNT_W-1:0] cnt,
   input logic [IDX_W-1:0] idx,
   input logic             mid,
   input logic             term,
   input logic             rx_s,
   input logic             frame11_i,
   input logic             line_o,
   input logic             err_o
);

   localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(2 ** (CNT_W - 1));
   localparam logic [IDX_W-1:0] INFO_C  = IDX_W'(DATA_BITS);
   localparam logic [IDX_W-1:0] SECOND_C = IDX_W'(DATA_BITS + 2);

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cnt == '0)); // R2
   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line_o); // R2
   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
   AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == '0 && rx_s && cnt <= HALF_C) |=> !busy); // R3
   AST_OUT_AT_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_o) |-> $past(mid)); // R4
   AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx > INFO_C && cnt > HALF_C) |-> line_o); // R5
   AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && !frame11_i && idx == SECOND_C)); // R7
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R10
   AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(term)); // R10

endmodule

bind char_regen char_regen_chk #(
   .CNT_W(CNT_W), .DATA_BITS(DATA_BITS), .IDX_W(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .cnt       (cnt),
   .idx       (idx),
   .mid       (mid),
   .term      (term),
   .rx_s      (rx_s),
   .frame11_i (frame11_i),
   .line_o    (line_o),
   .err_o     (err_o)
);

// File: tb/char_regen_bench.sv
module char_regen_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_i = 1'b1;
   logic frame11_i = 1'b0;
   logic odd_par_i = 1'b0;
   logic dist_en_i = 1'b0;
   logic line_o;
   logic err_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   char_regen u_char_regen (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_i),
      .frame11_i (frame11_i),
      .odd_par_i (odd_par_i),
      .dist_en_i (dist_en_i),
      .line_o    (line_o),
      .err_o     (err_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Level of the line at step t; boundary k is shifted by d cycles.
   function automatic logic level(input int t, input int k, input int d,
                                  input logic [10:0] lv, input int last);
      int e;
      e = t / 128;
      if (d > 0 && e == k && t < 128 * k + d) e = k - 1;
      if (d < 0 && e == k - 1 && t >= 128 * k + d) e = k;
      if (e > last) return 1'b1;
      return lv[e];
   endfunction

   task automatic send_char(input logic [7:0] data, input logic s1, input logic s2,
                            input int k, input int d, input int gap, input string req);
      logic [10:0] lv;
      int last, total, pulses, pulse_at;
      bit exp_err, timing_bad;
      last = frame11_i ? 10 : 9;
      lv = '1;
      lv[0] = 1'b0;
      for (int i = 0; i < 8; i++) lv[1 + i] = data[i];
      lv[9] = s1;
      lv[10] = s2;
      timing_bad = (k >= 1 && k <= last && lv[k] != lv[k - 1] && (d > 32 || d < -32));
      exp_err = ((^data) != odd_par_i) ||
                (dist_en_i && (!s1 || (frame11_i && !s2) || timing_bad));
      total = 128 * (last + 1) + gap;
      pulses = 0;
      pulse_at = -1;
      for (int t = 0; t < total; t++) begin
         @(negedge clk);
         if (err_o) begin
            pulses++;
            pulse_at = t;
         end
         for (int j = 0; j <= last; j++) begin
            if (t == 128 * j + 130) begin
               if (j == 0)
                  check(line_o == 1'b0, "R4 start", int'(line_o), 0);
               else if (j <= 8)
                  check(line_o == lv[j], "R4 info", int'(line_o), int'(lv[j]));
               else
                  check(line_o == 1'b1, "R5 stop", int'(line_o), 1);
            end
         end
         line_i = level(t, k, d, lv, last);
      end
      check(pulses == int'(exp_err), req, pulses, int'(exp_err));
      if (exp_err)
         check(pulse_at == 128 * (last + 1) + 1, "R10 timing", pulse_at, 128 * (last + 1) + 1);
   endtask

   task automatic send_glitch(input int len);
      int lows, pulses;
      lows = 0;
      pulses = 0;
      for (int t = 0; t < len + 300; t++) begin
         @(negedge clk);
         if (!line_o) lows++;
         if (err_o) pulses++;
         line_i = (t < len) ? 1'b0 : 1'b1;
      end
      check(lows == 0, "R3 output quiet", lows, 0);
      check(pulses == 0, "R3 no strobe", pulses, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lows, pulses;
      repeat (5) @(negedge clk);
      check(line_o == 1'b1, "R1 line_o", int'(line_o), 1);
      check(err_o == 1'b0, "R1 err_o", int'(err_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_o == 1'b1 && err_o == 1'b0, "R1 after release", int'(line_o), 1);

      // R2: long mark, nothing moves
      lows = 0;
      pulses = 0;
      for (int t = 0; t < 300; t++) begin
         @(negedge clk);
         if (!line_o) lows++;
         if (err_o) pulses++;
      end
      check(lows == 0, "R2 idle output", lows, 0);
      check(pulses == 0, "R2 idle strobe", pulses, 0);

      // Sweep: framing x parity sense, many information patterns (R6, R7)
      dist_en_i = 1'b1;
      for (int mode = 0; mode < 4; mode++) begin
         frame11_i = mode[1];
         odd_par_i = mode[0];
         for (int v = 0; v < 16; v++)
            send_char(8'(v * 53 + mode * 29), 1'b1, 1'b1, 0, 0, 3 + v, "R6 R7 parity");
      end

      // R8: boundary of element 1 moved around the quarter-bit limit
      frame11_i = 1'b0;
      odd_par_i = 1'b0;
      dist_en_i = 1'b1;
      send_char(8'h03, 1'b1, 1'b1, 1, -40, 5, "R8 d=-40");
      send_char(8'h03, 1'b1, 1'b1, 1, -33, 5, "R8 d=-33");
      send_char(8'h03, 1'b1, 1'b1, 1, -32, 5, "R8 d=-32");
      send_char(8'h03, 1'b1, 1'b1, 1, 32, 5, "R8 d=32");
      send_char(8'h03, 1'b1, 1'b1, 1, 33, 5, "R8 d=33");
      send_char(8'h03, 1'b1, 1'b1, 1, 40, 5, "R8 d=40");
      send_char(8'h5A, 1'b1, 1'b1, 4, 36, 5, "R8 mid-character");
      dist_en_i = 1'b0;
      send_char(8'h03, 1'b1, 1'b1, 1, 40, 5, "R8 disabled");

      // R9 / R5: stop read as space
      dist_en_i = 1'b1;
      send_char(8'h81, 1'b0, 1'b1, 0, 0, 5, "R9 stop space");
      dist_en_i = 1'b0;
      send_char(8'h81, 1'b0, 1'b1, 0, 0, 5, "R9 disabled");
      dist_en_i = 1'b1;
      frame11_i = 1'b1;
      send_char(8'h81, 1'b1, 1'b0, 0, 0, 5, "R7 R9 second stop");
      frame11_i = 1'b0;

      // R3: false starts, then a normal character
      send_glitch(1);
      send_glitch(30);
      send_glitch(64);
      send_char(8'hC3, 1'b1, 1'b1, 0, 0, 5, "R3 after glitch");
      // 65-cycle start accepted; all-ones fails odd sense
      dist_en_i = 1'b0;
      odd_par_i = 1'b1;
      send_char(8'hFF, 1'b1, 1'b1, 1, -63, 5, "R3 65-cycle start");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule